// File: doc/BRIEF.md
# Four-Pin Bidirectional GPIO Port with Analog Select

This block is a small memory-mapped I/O port with four pins. Pins 0 to 2 are bidirectional. Each has a direction bit, an output latch bit and an analog-select bit. Software reads the synchronized pin levels through a port register. A pin marked as analog reads back as 0 there, whatever its level.

Pin 3 is input only and has no direction or latch bit. A static configuration input decides its role. With the input low, pin 3 is a plain digital input that appears in bit 3 of the port register. With the input high, it is an active-low master-clear input, and after synchronization it raises a reset request. A build parameter gives a reduced variant in which only pin 3 exists.

The register bus is an address, a write strobe, write data, and read data that follows the address combinationally. The register offsets are PORT=0, LATCH=1, DIR=2 and ANSEL=3.

Top module: `gpio_quad_port`

## Requirements
- R1: After reset, DIR reads 0x07, ANSEL reads 0x07, LATCH reads 0x00 and `pad_oe` is 3'b000. The port register reads 0 in bits 2:0.
- R2: A DIR bit of 1 disables that pin's driver (`pad_oe` bit 0). A DIR bit of 0 enables the driver, and `pad_out` always carries the latch value.
- R3: A pin with its ANSEL bit set reads as 0 in the port register. A pin with its ANSEL bit clear reads its synchronized level.
- R4: The ANSEL bits have no effect on the drivers. An analog pin whose DIR bit is 0 is driven.
- R5: Reading LATCH returns the stored latch bits, not the pin levels.
- R6: A write to the PORT offset updates the output latches in the same way as a write to LATCH.
- R7: Each pin input passes through two flops. A change on `pad_in` appears on `rd_data` after the second rising clock edge, and not after the first.
- R8: With `mclr_en`=0, bit 3 of the port register reads the synchronized level of pin 3, and `mclr_req` stays 0.
- R9: With `mclr_en`=1, bit 3 of the port register reads 0. `mclr_req` goes to 1 two edges after pin 3 goes low, and drops again two edges after pin 3 goes high.
- R10: Bits 7:3 of LATCH, DIR and ANSEL, and bits 7:4 of PORT, read as 0. Writes to those bits are ignored.
- R11: In the reduced build (`REDUCED`=1):
  - `pad_oe` and `pad_out` stay 0.
  - LATCH, DIR and ANSEL read 0.
  - The port register carries only bit 3, and only while `mclr_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mclr_en | input | 1 | Pin 3 role: 1 = master-clear input, 0 = digital input |
| addr | input | AW (2) | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW (8) | Write data |
| rd_data | output | DW (8) | Read data for `addr` (combinational) |
| pad_in | input | NBI+1 (4) | Raw pin levels from the pads |
| pad_oe | output | NBI (3) | Driver enable per bidirectional pin |
| pad_out | output | NBI (3) | Drive value per bidirectional pin |
| mclr_req | output | 1 | Reset request from the master-clear pin |

## Verification
The port register is read under several pin patterns, each chosen to separate one effect:
- With every ANSEL bit clear, a pattern of alternating pin levels shows that each bit reads its own pin.
- Setting a single ANSEL bit under the same pattern shows that the masking applies to that pin only.
- A latch value that differs from the pin levels separates the LATCH register from the PORT register.
- Sampling a single pin edge after one clock and after two shows that the synchronizer is exactly two flops deep.

Pin 3 is driven low and high in each `mclr_en` setting. This separates the digital read path from the reset request. A second instance built in the reduced variant confirms that the bidirectional pins are absent.

// File: rtl/gpio_quad_port.sv
module gpio_quad_port #(
  parameter int DW      = 8,
  parameter int AW      = 2,
  parameter int NBI     = 3,
  parameter int SYNC    = 2,
  parameter bit REDUCED = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mclr_en,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [NBI:0]  pad_in,
  output logic [NBI-1:0] pad_oe,
  output logic [NBI-1:0] pad_out,
  output logic          mclr_req
);
  localparam int NP = NBI + 1;
  localparam logic [AW-1:0] A_PORT  = AW'(0);
  localparam logic [AW-1:0] A_LATCH = AW'(1);
  localparam logic [AW-1:0] A_DIR   = AW'(2);
  localparam logic [AW-1:0] A_ANSEL = AW'(3);
  localparam logic [NP-1:0] SYNC_RST = {1'b1, {NBI{1'b0}}};

  logic [NP-1:0] sync_q [SYNC];
  logic [NP-1:0] pin_s;
  logic [NBI-1:0] lat_q, dir_q, ana_q;
  logic [NBI-1:0] bidir_rd;
  logic           pin3_rd;
  logic [DW-1:0]  port_val;
  logic           unused_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) sync_q[i] <= SYNC_RST;
    end else begin
      sync_q[0] <= pad_in;
      for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign pin_s = sync_q[SYNC-1];

  generate
    if (REDUCED) begin : g_reduced
      assign lat_q    = '0;
      assign dir_q    = '1;
      assign ana_q    = '1;
      assign pad_oe   = '0;
      assign pad_out  = '0;
      assign bidir_rd = '0;
    end else begin : g_full
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lat_q <= '0;
          dir_q <= '1;
          ana_q <= '1;
        end else if (wr_en) begin
          if (addr == A_PORT || addr == A_LATCH) lat_q <= wr_data[NBI-1:0];
          if (addr == A_DIR)   dir_q <= wr_data[NBI-1:0];
          if (addr == A_ANSEL) ana_q <= wr_data[NBI-1:0];
        end
      end
      assign pad_oe   = ~dir_q;
      assign pad_out  = lat_q;
      assign bidir_rd = pin_s[NBI-1:0] & ~ana_q;
    end
  endgenerate

  assign pin3_rd  = ~mclr_en & pin_s[NBI];
  assign mclr_req = mclr_en & ~pin_s[NBI];
  assign port_val = DW'({pin3_rd, bidir_rd});
  assign unused_wr = ^wr_data[DW-1:NBI];

  always_comb begin
    rd_data = '0;
    case (addr)
      A_PORT:  rd_data = port_val;
      A_LATCH: rd_data = REDUCED ? '0 : DW'(lat_q);
      A_DIR:   rd_data = REDUCED ? '0 : DW'(dir_q);
      A_ANSEL: rd_data = REDUCED ? '0 : DW'(ana_q);
      default: rd_data = '0;
    endcase
  end
endmodule

module gpio_quad_port_chk #(
  parameter int DW      = 8,
  parameter int AW      = 2,
  parameter int NBI     = 3,
  parameter bit REDUCED = 1'b0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mclr_en,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic [NBI:0]  pad_in,
  input logic [NBI-1:0] pad_oe,
  input logic [NBI-1:0] pad_out,
  input logic          mclr_req
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_DIR_DRIVES_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(2)) |=> pad_oe == (REDUCED ? '0 : ~$past(wr_data[NBI-1:0]))); // R2
  AST_PORT_WRITES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == AW'(0) || addr == AW'(1))) |=> pad_out == (REDUCED ? '0 : $past(wr_data[NBI-1:0]))); // R6
  AST_DIGITAL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !mclr_en |-> !mclr_req); // R8
  AST_MCLR_BIT3_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr_en && addr == AW'(0)) |-> !rd_data[NBI]); // R9
  AST_MCLR_SYNC_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && mclr_en && $past(mclr_en) && !$past(pad_in[NBI]) && !$past(pad_in[NBI], 2))
    |-> mclr_req); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:NBI+1] == '0); // R10
endmodule

bind gpio_quad_port gpio_quad_port_chk #(.DW(DW), .AW(AW), .NBI(NBI), .REDUCED(REDUCED)) u_chk (
  .clk(clk), .rst_n(rst_n), .mclr_en(mclr_en), .addr(addr), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in), .pad_oe(pad_oe),
  .pad_out(pad_out), .mclr_req(mclr_req)
);

// File: tb/gpio_quad_port_bench.sv
`timescale 1ns/1ps
module gpio_quad_port_bench;
  localparam logic [1:0] PORT = 2'd0, LATCH = 2'd1, DIR = 2'd2, ANSEL = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclr_en = 1'b0;
  logic [1:0] addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] ext = 4'b1000;
  logic [7:0] rd_data, rd_red;
  logic [2:0] pad_oe, pad_out, oe_red, out_red;
  logic mclr_req, req_red;
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  gpio_quad_port u_gpio_quad_port (
    .clk(clk), .rst_n(rst_n), .mclr_en(mclr_en), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pad_in(ext), .pad_oe(pad_oe),
    .pad_out(pad_out), .mclr_req(mclr_req));

  gpio_quad_port #(.REDUCED(1'b1)) u_red (
    .clk(clk), .rst_n(rst_n), .mclr_en(mclr_en), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_red), .pad_in(ext), .pad_oe(oe_red),
    .pad_out(out_red), .mclr_req(req_red));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rd_data;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    ext = 4'b1111; settle();
    rd(DIR, v);   chk("R1 dir", v, 8'h07);
    rd(ANSEL, v); chk("R1 ansel", v, 8'h07);
    rd(LATCH, v); chk("R1 latch", v, 8'h00);
    chk("R1 oe", {5'd0, pad_oe}, 8'h00);
    rd(PORT, v);  chk("R1 port", v, 8'h08);
  endtask

  task automatic t_direction();
    wr(ANSEL, 8'h00); wr(LATCH, 8'h05); wr(DIR, 8'h02);
    chk("R2 oe", {5'd0, pad_oe}, 8'h05);
    chk("R2 out", {5'd0, pad_out}, 8'h05);
    wr(DIR, 8'h07);
    chk("R2 oe off", {5'd0, pad_oe}, 8'h00);
    chk("R2 out kept", {5'd0, pad_out}, 8'h05);
  endtask

  task automatic t_analog_read();
    logic [7:0] v;
    wr(ANSEL, 8'h00); ext = 4'b1010; settle();
    rd(PORT, v); chk("R3 digital", v, 8'h0A);
    wr(ANSEL, 8'h02);
    rd(PORT, v); chk("R3 analog masked", v, 8'h08);
    ext = 4'b1111; settle();
    rd(PORT, v); chk("R3 others live", v, 8'h0D);
  endtask

  task automatic t_analog_drive();
    wr(ANSEL, 8'h07); wr(DIR, 8'h00);
    chk("R4 analog driven", {5'd0, pad_oe}, 8'h07);
    wr(DIR, 8'h07);
  endtask

  task automatic t_latch_readback();
    logic [7:0] v;
    wr(ANSEL, 8'h00); wr(LATCH, 8'h06); ext = 4'b0001; settle();
    rd(LATCH, v); chk("R5 latch", v, 8'h06);
    rd(PORT, v);  chk("R5 port differs", v, 8'h01);
  endtask

  task automatic t_port_write();
    logic [7:0] v;
    wr(PORT, 8'h03);
    rd(LATCH, v); chk("R6 latch via port", v, 8'h03);
    chk("R6 pad_out", {5'd0, pad_out}, 8'h03);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    ext = 4'b0000; settle();
    ext = 4'b0001;
    @(posedge clk); @(negedge clk);
    rd(PORT, v); chk("R7 one edge", v, 8'h00);
    @(posedge clk); @(negedge clk);
    rd(PORT, v); chk("R7 two edges", v, 8'h01);
  endtask

  task automatic t_bit3_digital();
    logic [7:0] v;
    mclr_en = 1'b0; ext = 4'b0000; settle();
    rd(PORT, v); chk("R8 bit3 low", v, 8'h00);
    chk("R8 no req", {7'd0, mclr_req}, 8'h00);
    ext = 4'b1000; settle();
    rd(PORT, v); chk("R8 bit3 high", v, 8'h08);
  endtask

  task automatic t_mclr();
    logic [7:0] v;
    mclr_en = 1'b1; ext = 4'b1000; settle();
    rd(PORT, v); chk("R9 bit3 zero", v, 8'h00);
    chk("R9 idle", {7'd0, mclr_req}, 8'h00);
    ext = 4'b0000;
    @(posedge clk); @(negedge clk);
    chk("R9 one edge", {7'd0, mclr_req}, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R9 req", {7'd0, mclr_req}, 8'h01);
    ext = 4'b1000;
    @(posedge clk); @(negedge clk);
    chk("R9 held", {7'd0, mclr_req}, 8'h01);
    @(posedge clk); @(negedge clk);
    chk("R9 release", {7'd0, mclr_req}, 8'h00);
    mclr_en = 1'b0;
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    wr(DIR, 8'hFF);
    rd(DIR, v); chk("R10 dir upper", v, 8'h07);
    wr(LATCH, 8'hF8);
    rd(LATCH, v); chk("R10 latch upper", v, 8'h00);
    wr(ANSEL, 8'hF0);
    rd(ANSEL, v); chk("R10 ansel upper", v, 8'h00);
  endtask

  task automatic t_reduced();
    logic [7:0] v;
    mclr_en = 1'b0; wr(DIR, 8'h00); wr(LATCH, 8'h07);
    chk("R11 oe", {5'd0, oe_red}, 8'h00);
    chk("R11 out", {5'd0, out_red}, 8'h00);
    addr = DIR; #0.5; chk("R11 dir", rd_red, 8'h00);
    ext = 4'b1111; settle();
    addr = PORT; #0.5; v = rd_red; chk("R11 port", v, 8'h08);
    mclr_en = 1'b1; #0.5; chk("R11 port mclr", rd_red, 8'h00);
    mclr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direction();
    t_analog_read();
    t_analog_drive();
    t_latch_readback();
    t_port_write();
    t_sync();
    t_bit3_digital();
    t_mclr();
    t_unimpl();
    t_reduced();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule